// File: doc/BRIEF.md
# Endpoint Configuration Register File with Capability Chain

This block is the endpoint-side store for a PCI-compatible configuration space. A bus driver issues dword-addressed requests, each with a write flag, four byte enables and write data. The block answers reads with a registered response one cycle later and applies writes lane by lane. The standard type-0 header sits in dwords 0 through 15 (byte offsets 0x00 to 0x3C). It is the only part of the space whose layout every device shares. Everything beyond the header is found by following pointers.

The capability pointer byte at 0x34 leads to a power-management record at 0x40. That record's next pointer leads to an MSI record packed directly behind it at 0x48, with no reserved dwords in between. The MSI record ends the chain. Software that walks the chain finds every record without assuming a fixed register map. Identity fields are fixed by parameters. Only the command bits, the power-management control word and the MSI control, address and data words hold state.

Top module: `cfgsp_top`

## Requirements
- R1: After reset the command word, the power state, the PME enable, MSI enable, the multiple-message enable field and the MSI address and data words are all zero, and `rsp_valid` is low.
- R2: Dword 0 reads {device ID, vendor ID}, dword 2 reads {class code, revision}, dword 11 reads {subsystem ID, subsystem vendor ID} and dword 15 reads the interrupt pin in bits [15:8], all from parameters. Writes to these dwords leave their read value unchanged.
- R3: Bit 20 of dword 1 (bit 4 of the status half at byte 0x06) always reads 1. Dword 13 reads 0x00000040, so the capability pointer byte at 0x34 holds 0x40.
- R4: The first dword of each capability record holds the ID in bits [7:0] and the next pointer in bits [15:8]. Dword 16 (0x40) reads ID 0x01 with next 0x48. Dword 18 (0x48) reads ID 0x05 with next 0x00, which ends the chain.
- R5: In dword 1 only command bits 0, 1, 2, 6, 8 and 10 (mask 0x0547) are writable. All other bits keep their fixed values.
- R6: Dword 17 holds the power state in bits [1:0] and PME enable in bit 8. A written power state of 0 or 3 is accepted. A written value of 1 or 2 leaves the power state unchanged, while bit 8 is still written. All other bits read 0. Dword 16 bits [31:16] read the PM capabilities parameter.
- R7: Writing 0x00010000 to dword 18 with all byte enables sets MSI enable (bit 16). Bits [22:20] are the writable multiple-message enable field. A written value larger than the capable field in bits [19:17] is stored as the capable value. Bit 23 reads the 64-bit-address parameter.
- R8: With 64-bit addressing, dword 19 (0x4C) holds the message address low word with bits [1:0] reading 0, dword 20 (0x50) holds the address high word, and dword 21 (0x54) holds the message data in bits [15:0], with bits [31:16] reading 0.
- R9: On every writable dword, each byte lane changes only when its byte enable is set. A write with no enables changes nothing.
- R10: Unimplemented dwords (4 to 10, 12, 14, and 22 and above with 64-bit addressing) read zero, and writes to them have no effect.
- R11: `rsp_valid` rises exactly one cycle after a read request and never after a write. The read data shows the state before any write issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw | input | 6 | Dword index (byte offset / 4) |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
A read's registered response and a write to the same register can land on the same clock edge. This happens when a read of the MSI address word is followed directly, in the next cycle, by a write to that word. The bench drives that read, write, read sequence back to back. It requires the first response to carry the value from before the write, no response to appear for the write, and the second read to show the new value.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int CFG_DW_AW = 6;
    localparam int HDR_LAST_DW = 15;

    localparam logic [15:0] CMD_WMASK       = 16'h0547;
    localparam int          STS_CAPLIST_BIT = 4;

    localparam logic [7:0] CAP_ID_PM     = 8'h01;
    localparam logic [7:0] CAP_ID_MSI    = 8'h05;
    localparam logic [7:0] CAP_CHAIN_END = 8'h00;

    localparam logic [7:0] PM_BASE_BYTE  = 8'h40;
    localparam logic [7:0] PM_LEN_BYTES  = 8'h08;
    localparam logic [7:0] MSI_BASE_BYTE = PM_BASE_BYTE + PM_LEN_BYTES;

    localparam logic [31:0] PM_CSR_WMASK  = 32'h0000_0103;
    localparam logic [31:0] MSI_CTL_WMASK = 32'h0071_0000;
    localparam logic [31:0] MSI_DATA_MASK = 32'h0000_FFFF;
    localparam logic [31:0] MSI_ALO_MASK  = 32'hFFFF_FFFC;

    typedef enum logic [1:0] {
        PS_D0    = 2'd0,
        PS_D1    = 2'd1,
        PS_D2    = 2'd2,
        PS_D3HOT = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic [CFG_DW_AW-1:0] dw;
        logic [3:0]           be;
        logic [31:0]          data;
    } cfg_req_t;

    function automatic logic [CFG_DW_AW-1:0] byte_to_dw(input logic [7:0] b);
        return CFG_DW_AW'(b >> 2);
    endfunction

    function automatic logic [31:0] be_merge(input logic [31:0] cur,
                                             input logic [31:0] nw,
                                             input logic [3:0]  be);
        logic [31:0] res;
        for (int i = 0; i < 4; i++) begin
            res[i*8 +: 8] = be[i] ? nw[i*8 +: 8] : cur[i*8 +: 8];
        end
        return res;
    endfunction

    function automatic logic is_write_to(input cfg_req_t r,
                                         input logic [CFG_DW_AW-1:0] dw);
        return r.valid && r.write && (r.dw == dw);
    endfunction

endpackage

// File: rtl/cfgsp_hdr.sv
module cfgsp_hdr
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [7:0]  REV_ID     = 8'h02,
    parameter logic [23:0] CLASS_CODE = 24'h058000,
    parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
    parameter logic [15:0] SUBSYS_ID  = 16'h0001,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [7:0]  CAP_PTR    = 8'h40
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    output logic [31:0] rd_data
);

    localparam logic [CFG_DW_AW-1:0] DW_ID     = 6'd0;
    localparam logic [CFG_DW_AW-1:0] DW_CMDSTS = 6'd1;
    localparam logic [CFG_DW_AW-1:0] DW_CLASS  = 6'd2;
    localparam logic [CFG_DW_AW-1:0] DW_SUBSYS = 6'd11;
    localparam logic [CFG_DW_AW-1:0] DW_CAPPTR = 6'd13;
    localparam logic [CFG_DW_AW-1:0] DW_INTR   = 6'd15;
    localparam logic [31:0] STS_FIXED = 32'h1 << (16 + STS_CAPLIST_BIT);
    localparam logic [31:0] CMD_MASK32 = {16'h0000, CMD_WMASK};

    logic [31:0] cmd_q;
    logic [31:0] cmd_merged;

    assign cmd_merged = be_merge(cmd_q, req.data, req.be);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (is_write_to(req, DW_CMDSTS)) begin
            cmd_q <= cmd_merged & CMD_MASK32;
        end
    end

    always_comb begin
        rd_data = '0;
        case (req.dw)
            DW_ID:     rd_data = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTS: rd_data = cmd_q | STS_FIXED;
            DW_CLASS:  rd_data = {CLASS_CODE, REV_ID};
            DW_SUBSYS: rd_data = {SUBSYS_ID, SUBSYS_VID};
            DW_CAPPTR: rd_data = {24'h000000, CAP_PTR};
            DW_INTR:   rd_data = {16'h0000, INT_PIN, 8'h00};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cfgsp_pm.sv
module cfgsp_pm
    import cfgsp_pkg::*;
#(
    parameter logic [CFG_DW_AW-1:0] BASE_DW  = 6'd16,
    parameter logic [7:0]           NEXT_PTR = 8'h48,
    parameter logic [15:0]          PMC      = 16'h0003
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    output logic [31:0] rd_data,
    output pwr_state_e  pwr_state
);

    localparam logic [CFG_DW_AW-1:0] CSR_DW = BASE_DW + 6'd1;

    logic [31:0] csr_q;
    logic [31:0] csr_merged;
    logic [31:0] csr_next;
    logic        ps_ok;

    assign csr_merged = be_merge(csr_q, req.data, req.be);
    assign ps_ok = (csr_merged[1:0] == PS_D0) || (csr_merged[1:0] == PS_D3HOT);

    always_comb begin
        csr_next = csr_merged & PM_CSR_WMASK;
        if (!ps_ok) begin
            csr_next[1:0] = csr_q[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q <= '0;
        end else if (is_write_to(req, CSR_DW)) begin
            csr_q <= csr_next;
        end
    end

    assign pwr_state = pwr_state_e'(csr_q[1:0]);

    always_comb begin
        rd_data = '0;
        if (req.dw == BASE_DW) begin
            rd_data = {PMC, NEXT_PTR, CAP_ID_PM};
        end else if (req.dw == CSR_DW) begin
            rd_data = csr_q;
        end
    end

endmodule

// File: rtl/cfgsp_msi.sv
module cfgsp_msi
    import cfgsp_pkg::*;
#(
    parameter logic [CFG_DW_AW-1:0] BASE_DW = 6'd18,
    parameter logic [2:0]           MMC     = 3'd2,
    parameter bit                   ADDR64  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    output logic [31:0] rd_data,
    output logic        msi_en
);

    localparam logic [CFG_DW_AW-1:0] ALO_DW  = BASE_DW + 6'd1;
    localparam logic [CFG_DW_AW-1:0] AHI_DW  = BASE_DW + 6'd2;
    localparam logic [CFG_DW_AW-1:0] DATA_DW = ADDR64 ? BASE_DW + 6'd3 : BASE_DW + 6'd2;
    localparam logic [31:0] CTL_FIXED =
        {8'h00, ADDR64, 3'b000, MMC, 1'b0, CAP_CHAIN_END, CAP_ID_MSI};

    logic [31:0] ctl_q;
    logic [31:0] ctl_masked;
    logic [31:0] ctl_next;
    logic [31:0] alo_q;
    logic [31:0] data_q;
    logic [31:0] ahi_w;

    assign ctl_masked = be_merge(ctl_q, req.data, req.be) & MSI_CTL_WMASK;

    always_comb begin
        ctl_next = ctl_masked;
        if (ctl_masked[22:20] > MMC) begin
            ctl_next[22:20] = MMC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            alo_q  <= '0;
            data_q <= '0;
        end else begin
            if (is_write_to(req, BASE_DW)) begin
                ctl_q <= ctl_next;
            end
            if (is_write_to(req, ALO_DW)) begin
                alo_q <= be_merge(alo_q, req.data, req.be) & MSI_ALO_MASK;
            end
            if (is_write_to(req, DATA_DW)) begin
                data_q <= be_merge(data_q, req.data, req.be) & MSI_DATA_MASK;
            end
        end
    end

    generate
        if (ADDR64) begin : g_addr_hi
            logic [31:0] ahi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ahi_q <= '0;
                end else if (is_write_to(req, AHI_DW)) begin
                    ahi_q <= be_merge(ahi_q, req.data, req.be);
                end
            end
            assign ahi_w = ahi_q;
        end else begin : g_addr32
            assign ahi_w = '0;
        end
    endgenerate

    assign msi_en = ctl_q[16];

    always_comb begin
        rd_data = '0;
        if (req.dw == BASE_DW) begin
            rd_data = ctl_q | CTL_FIXED;
        end else if (req.dw == ALO_DW) begin
            rd_data = alo_q;
        end else if (req.dw == DATA_DW) begin
            rd_data = data_q;
        end else if (ADDR64 && (req.dw == AHI_DW)) begin
            rd_data = ahi_w;
        end
    end

endmodule

// File: rtl/cfgsp_top.sv
module cfgsp_top
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID  = 16'h3C4D,
    parameter logic [7:0]  REV_ID     = 8'h02,
    parameter logic [23:0] CLASS_CODE = 24'h058000,
    parameter logic [15:0] SUBSYS_VID = 16'h1A2B,
    parameter logic [15:0] SUBSYS_ID  = 16'h0001,
    parameter logic [7:0]  INT_PIN    = 8'h01,
    parameter logic [15:0] PM_CAPS    = 16'h0003,
    parameter logic [2:0]  MSI_MMC    = 3'd2,
    parameter bit          MSI_ADDR64 = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CFG_DW_AW-1:0] req_dw,
    input  logic [3:0]           req_be,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata
);

    localparam logic [CFG_DW_AW-1:0] PM_DW  = byte_to_dw(PM_BASE_BYTE);
    localparam logic [CFG_DW_AW-1:0] MSI_DW = byte_to_dw(MSI_BASE_BYTE);

    cfg_req_t    req;
    logic [31:0] hdr_rd;
    logic [31:0] pm_rd;
    logic [31:0] msi_rd;
    logic [31:0] rd_any;
    logic        msi_en_w;
    pwr_state_e  pm_state_w;

    assign req = '{valid: req_valid, write: req_write, dw: req_dw,
                   be: req_be, data: req_wdata};

    cfgsp_hdr #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REV_ID    (REV_ID),
        .CLASS_CODE(CLASS_CODE),
        .SUBSYS_VID(SUBSYS_VID),
        .SUBSYS_ID (SUBSYS_ID),
        .INT_PIN   (INT_PIN),
        .CAP_PTR   (PM_BASE_BYTE)
    ) u_hdr (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .rd_data(hdr_rd)
    );

    cfgsp_pm #(
        .BASE_DW (PM_DW),
        .NEXT_PTR(MSI_BASE_BYTE),
        .PMC     (PM_CAPS)
    ) u_pm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .rd_data  (pm_rd),
        .pwr_state(pm_state_w)
    );

    cfgsp_msi #(
        .BASE_DW(MSI_DW),
        .MMC    (MSI_MMC),
        .ADDR64 (MSI_ADDR64)
    ) u_msi (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .rd_data(msi_rd),
        .msi_en (msi_en_w)
    );

    assign rd_any = hdr_rd | pm_rd | msi_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_rdata <= rd_any;
            end
        end
    end

endmodule

// File: rtl/cfgsp_chk.sv
module cfgsp_chk
    import cfgsp_pkg::*;
#(
    parameter logic [CFG_DW_AW-1:0] PM_DW  = 6'd16,
    parameter logic [CFG_DW_AW-1:0] MSI_DW = 6'd18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [CFG_DW_AW-1:0] req_dw,
    input logic [3:0]           req_be,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic                 msi_en,
    input pwr_state_e           pm_state
);

    function automatic logic unimpl(input logic [CFG_DW_AW-1:0] dw);
        return (dw >= 6'd4 && dw <= 6'd10) || dw == 6'd12 || dw == 6'd14 || dw >= 6'd22;
    endfunction

    assert_rsp_after_read_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    assert_rsp_only_reads_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_caplist_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_dw) == 6'd1) |-> rsp_rdata[20]);

    assert_pm_link_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_dw) == PM_DW) |-> (rsp_rdata[15:0] == 16'h4801));

    assert_chain_end_R4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_dw) == MSI_DW) |-> (rsp_rdata[15:0] == 16'h0005));

    assert_msi_en_write_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(msi_en) |-> $past(req_valid && req_write && req_dw == MSI_DW && req_be[2]));

    assert_pwr_state_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (pm_state == PS_D0) || (pm_state == PS_D3HOT));

    assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && unimpl($past(req_dw))) |-> (rsp_rdata == 32'h0));

endmodule

bind cfgsp_top cfgsp_chk #(
    .PM_DW (cfgsp_pkg::byte_to_dw(cfgsp_pkg::PM_BASE_BYTE)),
    .MSI_DW(cfgsp_pkg::byte_to_dw(cfgsp_pkg::MSI_BASE_BYTE))
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_dw   (req_dw),
    .req_be   (req_be),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .msi_en   (msi_en_w),
    .pm_state (pm_state_w)
);

// File: tb/cfgsp_top_tb.sv
module cfgsp_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_dw = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cfgsp_top u_dut (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_dw   (req_dw),
        .req_be   (req_be),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_dw = dw; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = dw; req_be = '0; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        chk("R11 read response valid", {31'h0, rsp_valid}, 32'h1);
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] dw, input logic [31:0] exp);
        logic [31:0] d;
        cfg_read(dw, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid low after reset", {31'h0, rsp_valid}, 32'h0);
        rd_chk("R1 R3 command clear, caplist bit", 6'd1, 32'h0010_0000);
        rd_chk("R1 pm csr clear", 6'd17, 32'h0);
        rd_chk("R1 R7 msi ctl reset", 6'd18, 32'h0084_0005);
        rd_chk("R1 msi addr lo", 6'd19, 32'h0);
        rd_chk("R1 msi addr hi", 6'd20, 32'h0);
        rd_chk("R1 msi data", 6'd21, 32'h0);
    endtask

    task automatic t_identity;
        rd_chk("R2 id", 6'd0, 32'h3C4D_1A2B);
        cfg_write(6'd0, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R2 id after write", 6'd0, 32'h3C4D_1A2B);
        rd_chk("R2 class", 6'd2, 32'h0580_0002);
        cfg_write(6'd2, 4'hF, 32'h0);
        rd_chk("R2 class after write", 6'd2, 32'h0580_0002);
        rd_chk("R2 subsystem", 6'd11, 32'h0001_1A2B);
        cfg_write(6'd15, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R2 int pin", 6'd15, 32'h0000_0100);
        cfg_write(6'd13, 4'hF, 32'h0000_00AA);
        rd_chk("R3 cap pointer", 6'd13, 32'h0000_0040);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        logic [5:0]  p;
        cfg_read(6'd13, d);
        p = d[7:2];
        chk("R4 first record index", {26'h0, p}, 32'd16);
        cfg_read(p, d);
        chk("R4 pm record head", d, 32'h0003_4801);
        p = d[15:10];
        chk("R4 msi right after pm", {26'h0, p}, 32'd18);
        cfg_read(p, d);
        chk("R4 msi id", {24'h0, d[7:0]}, 32'h05);
        chk("R4 chain end", {24'h0, d[15:8]}, 32'h00);
    endtask

    task automatic t_command;
        cfg_write(6'd1, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R5 command mask", 6'd1, 32'h0010_0547);
        cfg_write(6'd1, 4'b0010, 32'h0);
        rd_chk("R9 command lane1 only", 6'd1, 32'h0010_0047);
        cfg_write(6'd1, 4'b0000, 32'h0);
        rd_chk("R9 command no enables", 6'd1, 32'h0010_0047);
    endtask

    task automatic t_pm;
        cfg_write(6'd17, 4'hF, 32'h0000_0003);
        rd_chk("R6 D3hot accepted", 6'd17, 32'h0000_0003);
        cfg_write(6'd17, 4'hF, 32'h0000_0001);
        rd_chk("R6 D1 rejected", 6'd17, 32'h0000_0003);
        cfg_write(6'd17, 4'hF, 32'hFFFF_0100);
        rd_chk("R6 D0 and PME enable", 6'd17, 32'h0000_0100);
        cfg_write(6'd17, 4'hF, 32'h0000_0102);
        rd_chk("R6 D2 rejected, pme kept", 6'd17, 32'h0000_0100);
        cfg_write(6'd17, 4'b0001, 32'h0);
        rd_chk("R9 pm lane0 only", 6'd17, 32'h0000_0100);
        rd_chk("R6 pm caps", 6'd16, 32'h0003_4801);
    endtask

    task automatic t_msi;
        cfg_write(6'd18, 4'hF, 32'h0001_0000);
        rd_chk("R7 msi enable", 6'd18, 32'h0085_0005);
        cfg_write(6'd18, 4'hF, 32'h0071_0000);
        rd_chk("R7 mme clamped", 6'd18, 32'h00A5_0005);
        cfg_write(6'd18, 4'b1011, 32'h0);
        rd_chk("R9 msi lane2 off", 6'd18, 32'h00A5_0005);
        cfg_write(6'd18, 4'hF, 32'h0011_0000);
        rd_chk("R7 mme in range", 6'd18, 32'h0095_0005);
    endtask

    task automatic t_msi_regs;
        cfg_write(6'd19, 4'hF, 32'hFEE0_0003);
        rd_chk("R8 addr lo low bits", 6'd19, 32'hFEE0_0000);
        cfg_write(6'd20, 4'hF, 32'h1234_5678);
        rd_chk("R8 addr hi", 6'd20, 32'h1234_5678);
        cfg_write(6'd21, 4'hF, 32'hABCD_1234);
        rd_chk("R8 data low half", 6'd21, 32'h0000_1234);
        cfg_write(6'd20, 4'b0101, 32'h0);
        rd_chk("R9 addr hi lanes 0,2", 6'd20, 32'h1200_5600);
    endtask

    task automatic t_unimpl;
        cfg_write(6'd4, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R10 bar reads zero", 6'd4, 32'h0);
        rd_chk("R10 reserved 0x38", 6'd14, 32'h0);
        cfg_write(6'd22, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R10 past chain", 6'd22, 32'h0);
        rd_chk("R10 top dword", 6'd63, 32'h0);
        rd_chk("R10 msi data untouched", 6'd21, 32'h0000_1234);
    endtask

    task automatic t_timing;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = 6'd19;
        @(negedge clk);
        chk("R11 rsp valid after read", {31'h0, rsp_valid}, 32'h1);
        chk("R11 pre-write value", rsp_rdata, 32'hFEE0_0000);
        req_write = 1'b1; req_be = 4'hF; req_wdata = 32'h0000_1000;
        @(negedge clk);
        chk("R11 no rsp for write", {31'h0, rsp_valid}, 32'h0);
        req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 rsp after second read", {31'h0, rsp_valid}, 32'h1);
        chk("R11 post-write value", rsp_rdata, 32'h0000_1000);
        @(negedge clk);
        chk("R11 rsp drops when idle", {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_identity();
        t_chain();
        t_command();
        t_pm();
        t_msi();
        t_msi_regs();
        t_unimpl();
        t_timing();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule